// File: doc/BRIEF.md
# Synthesizer Control Word Dispatcher

This block receives complete control words that a serial front end has already assembled, each qualified by a one-cycle load strobe. The two lowest bits of the word are an address. They steer the remaining payload into one of three holding registers: the reference-divider setting, the feedback-divider setting, or the function setting. The fourth address, initialization, also writes the function register and additionally arms a phase-alignment sequence.

The function register is decoded into individual control outputs: counter hold, charge-pump high impedance, power-down request and mode, output multiplexer select, phase detector polarity, fast-lock enable and mode, and the fast-lock timeout code. The block also produces a registered one-cycle alignment pulse. This pulse forces the downstream reference, feedback and timeout counters back to their load state. It fires on an initialization write and on the first feedback-divider write that follows it, so that both divider chains restart in step.

Top module: `synth_word_router`

## Requirements
- R1: The address in word bits [1:0] routes the payload word[WORD_W-1:2] as follows: 0 to the reference register, 1 to the feedback register, 2 to the function register, 3 to the function register as an initialization write. The other registers keep their contents. The new contents appear in the cycle after the strobe edge.
- R2: An initialization write (address 3) loads the function register with exactly the payload that an address-2 write would load.
- R3: An initialization write raises `align_pulse` for the one cycle after the strobe edge.
- R4: The first feedback write (address 1) after an initialization write raises `align_pulse` for one cycle.
- R5: Writes to address 0 or 2, and any feedback write after the first one following an initialization, leave `align_pulse` low. This holds until another initialization write.
- R6: Word bit 2 (counter hold) drives `cnt_hold` high and also forces `cp_tri` high. It has no effect on `pwr_dn`.
- R7: The function outputs decode these word bits: 3 `pwr_dn`, 6:4 `mux_sel`, 7 `pd_pol`, 8 `cp_tri` (ORed with bit 2), 9 `fl_en`, 10 `fl_mode`, 14:11 `fl_timer`, 15 `pwr_sync`.
- R8: A synchronous reset clears all three registers and the pending-first-feedback state. A strobe in a reset cycle is ignored.
- R9: `align_pulse` never stays high for two cycles unless a second qualifying write arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld | input | 1 | Word load strobe, one cycle per word |
| word | input | WORD_W | Control word; bits [1:0] are the address |
| ref_word | output | WORD_W-2 | Reference divider register contents |
| fb_word | output | WORD_W-2 | Feedback divider register contents |
| fn_word | output | WORD_W-2 | Function register contents |
| cnt_hold | output | 1 | Hold counters at load state |
| cp_tri | output | 1 | Charge pump high impedance |
| pwr_dn | output | 1 | Power-down request |
| pwr_sync | output | 1 | Power-down waits for a charge pump event |
| mux_sel | output | 3 | Output multiplexer select |
| pd_pol | output | 1 | Phase detector polarity |
| fl_en | output | 1 | Fast-lock enable |
| fl_mode | output | 1 | Fast-lock mode select |
| fl_timer | output | 4 | Fast-lock timeout code |
| align_pulse | output | 1 | One-cycle counter alignment reset |

## Verification
The assertions take for granted that `ld` is a single-cycle strobe and that the address field of a strobed word is always driven to a known value. The bench drives only whole words at the falling edge and drops `ld` before the next rising edge. The address sequence is chosen so that initialization, repeated feedback writes and the other addresses appear in many orders. One strobe is deliberately placed in a reset cycle to confirm that it is ignored.

// File: rtl/synth_ctl_pkg.sv
package synth_ctl_pkg;
  typedef enum logic [1:0] {
    ADR_REF  = 2'd0,
    ADR_FB   = 2'd1,
    ADR_FN   = 2'd2,
    ADR_INIT = 2'd3
  } word_addr_e;

  // payload bit positions (payload = word >> 2)
  localparam int P_HOLD    = 0;
  localparam int P_PDN     = 1;
  localparam int P_MUX_LO  = 2;
  localparam int P_POL     = 5;
  localparam int P_CPTRI   = 6;
  localparam int P_FLEN    = 7;
  localparam int P_FLMODE  = 8;
  localparam int P_TMR_LO  = 9;
  localparam int P_PSYNC   = 13;
  localparam int P_MIN_W   = 14;

  localparam int N_REGS    = 3;
  localparam int IDX_REF   = 0;
  localparam int IDX_FB    = 1;
  localparam int IDX_FN    = 2;
endpackage

// File: rtl/word_decoder.sv
module word_decoder
  import synth_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ld,
  input  logic [1:0] addr,
  output logic       wr_ref,
  output logic       wr_fb,
  output logic       wr_fn,
  output logic       wr_init
);
  logic go;
  assign go = ld && !rst;

  always_comb begin
    wr_ref  = 1'b0;
    wr_fb   = 1'b0;
    wr_fn   = 1'b0;
    wr_init = 1'b0;
    if (go) begin
      unique case (word_addr_e'(addr))
        ADR_REF:  wr_ref  = 1'b1;
        ADR_FB:   wr_fb   = 1'b1;
        ADR_FN:   wr_fn   = 1'b1;
        ADR_INIT: wr_init = 1'b1;
        default:  ;
      endcase
    end
  end

  // R1
  sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_ref, wr_fb, wr_fn, wr_init}));

  // R8
  rst_blocks_chk: assert property (@(posedge clk)
    rst |-> !(wr_ref || wr_fb || wr_fn || wr_init));
endmodule

// File: rtl/ctl_latch.sv
module ctl_latch #(
  parameter int W = 22
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= d;
  end

  // R1
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(q));
endmodule

// File: rtl/align_pulse_gen.sv
module align_pulse_gen (
  input  logic clk,
  input  logic rst,
  input  logic init_wr,
  input  logic fb_wr,
  output logic pulse
);
  logic pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      pulse   <= 1'b0;
    end else begin
      pulse <= init_wr || (fb_wr && pending);
      if (init_wr)    pending <= 1'b1;
      else if (fb_wr) pending <= 1'b0;
    end
  end

  // R3
  init_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    init_wr |=> pulse && pending);

  // R4
  first_fb_chk: assert property (@(posedge clk) disable iff (rst)
    (fb_wr && pending) |=> pulse && !pending);

  // R5
  later_fb_chk: assert property (@(posedge clk) disable iff (rst)
    (fb_wr && !pending) |=> !pulse);

  // R9
  single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (!init_wr && !fb_wr) |=> !pulse);
endmodule

// File: rtl/synth_word_router.sv
module synth_word_router
  import synth_ctl_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld,
  input  logic [WORD_W-1:0] word,
  output logic [WORD_W-3:0] ref_word,
  output logic [WORD_W-3:0] fb_word,
  output logic [WORD_W-3:0] fn_word,
  output logic              cnt_hold,
  output logic              cp_tri,
  output logic              pwr_dn,
  output logic              pwr_sync,
  output logic [2:0]        mux_sel,
  output logic              pd_pol,
  output logic              fl_en,
  output logic              fl_mode,
  output logic [3:0]        fl_timer,
  output logic              align_pulse
);
  localparam int PAY_W = WORD_W - 2;

  logic [PAY_W-1:0] payload;
  logic             wr_ref, wr_fb, wr_fn, wr_init;
  logic [N_REGS-1:0] reg_en;
  logic [PAY_W-1:0]  reg_q [N_REGS];

  assign payload = word[WORD_W-1:2];

  word_decoder u_dec (
    .clk     (clk),
    .rst     (rst),
    .ld      (ld),
    .addr    (word[1:0]),
    .wr_ref  (wr_ref),
    .wr_fb   (wr_fb),
    .wr_fn   (wr_fn),
    .wr_init (wr_init)
  );

  assign reg_en[IDX_REF] = wr_ref;
  assign reg_en[IDX_FB]  = wr_fb;
  assign reg_en[IDX_FN]  = wr_fn || wr_init;

  for (genvar g = 0; g < N_REGS; g++) begin : g_reg
    ctl_latch #(.W(PAY_W)) u_reg (
      .clk (clk),
      .rst (rst),
      .en  (reg_en[g]),
      .d   (payload),
      .q   (reg_q[g])
    );
  end

  assign ref_word = reg_q[IDX_REF];
  assign fb_word  = reg_q[IDX_FB];
  assign fn_word  = reg_q[IDX_FN];

  assign cnt_hold = fn_word[P_HOLD];
  assign cp_tri   = fn_word[P_HOLD] || fn_word[P_CPTRI];
  assign pwr_dn   = fn_word[P_PDN];
  assign pwr_sync = fn_word[P_PSYNC];
  assign mux_sel  = fn_word[P_MUX_LO +: 3];
  assign pd_pol   = fn_word[P_POL];
  assign fl_en    = fn_word[P_FLEN];
  assign fl_mode  = fn_word[P_FLMODE];
  assign fl_timer = fn_word[P_TMR_LO +: 4];

  align_pulse_gen u_align (
    .clk     (clk),
    .rst     (rst),
    .init_wr (wr_init),
    .fb_wr   (wr_fb),
    .pulse   (align_pulse)
  );

  initial begin
    if (PAY_W < P_MIN_W) $error("WORD_W too small for function fields");
  end

  // R2
  init_loads_fn_chk: assert property (@(posedge clk) disable iff (rst)
    (ld && word[1:0] == ADR_INIT) |=> fn_word == $past(payload));

  // R8
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (align_pulse == 1'b0) && (fn_word == '0) && (fb_word == '0) && (ref_word == '0));

  // R6
  hold_forces_tri_chk: assert property (@(posedge clk) disable iff (rst)
    (ld && word[1:0] == ADR_FN && word[2] && !word[3]) |=> cnt_hold && cp_tri && !pwr_dn);
endmodule

// File: tb/tb_synth_word_router.sv
module tb_synth_word_router;
  localparam int WORD_W = 24;
  localparam int PAY_W  = WORD_W - 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              ld  = 1'b0;
  logic [WORD_W-1:0] word = '0;
  logic [PAY_W-1:0]  ref_word, fb_word, fn_word;
  logic              cnt_hold, cp_tri, pwr_dn, pwr_sync, pd_pol, fl_en, fl_mode, align_pulse;
  logic [2:0]        mux_sel;
  logic [3:0]        fl_timer;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [PAY_W-1:0] m_ref = '0, m_fb = '0, m_fn = '0;
  bit               m_pend = 0;

  always #10 clk = ~clk;

  synth_word_router #(.WORD_W(WORD_W)) dut (
    .clk(clk), .rst(rst), .ld(ld), .word(word),
    .ref_word(ref_word), .fb_word(fb_word), .fn_word(fn_word),
    .cnt_hold(cnt_hold), .cp_tri(cp_tri), .pwr_dn(pwr_dn), .pwr_sync(pwr_sync),
    .mux_sel(mux_sel), .pd_pol(pd_pol), .fl_en(fl_en), .fl_mode(fl_mode),
    .fl_timer(fl_timer), .align_pulse(align_pulse)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_regs(input bit exp_pulse);
    chk(ref_word == m_ref, "R1 ref", 32'(ref_word), 32'(m_ref));
    chk(fb_word  == m_fb,  "R1 fb",  32'(fb_word),  32'(m_fb));
    chk(fn_word  == m_fn,  "R2 fn",  32'(fn_word),  32'(m_fn));
    chk(align_pulse == exp_pulse, "R3/R4/R5 align_pulse", 32'(align_pulse), 32'(exp_pulse));
    chk(cnt_hold == m_fn[0], "R6 cnt_hold", 32'(cnt_hold), 32'(m_fn[0]));
    chk(cp_tri == (m_fn[0] | m_fn[6]), "R6 cp_tri", 32'(cp_tri), 32'(m_fn[0] | m_fn[6]));
    chk({pwr_sync, fl_timer, fl_mode, fl_en, pd_pol, mux_sel, pwr_dn} ==
        {m_fn[13], m_fn[12:9], m_fn[8], m_fn[7], m_fn[5], m_fn[4:2], m_fn[1]},
        "R7 fields",
        32'({pwr_sync, fl_timer, fl_mode, fl_en, pd_pol, mux_sel, pwr_dn}),
        32'({m_fn[13], m_fn[12:9], m_fn[8], m_fn[7], m_fn[5], m_fn[4:2], m_fn[1]}));
  endtask

  // strobe one word, then check the outputs after the edge and in the idle cycle after
  task automatic put(input logic [1:0] a, input logic [PAY_W-1:0] p);
    bit exp_pulse;
    @(negedge clk);
    ld = 1'b1;
    word = {p, a};
    exp_pulse = (a == 2'd3) || (a == 2'd1 && m_pend);
    case (a)
      2'd0: m_ref = p;
      2'd1: begin m_fb = p; m_pend = 0; end
      2'd2: m_fn = p;
      default: begin m_fn = p; m_pend = 1; end
    endcase
    @(negedge clk);
    ld = 1'b0;
    check_regs(exp_pulse);
    @(negedge clk);
    // R9: pulse drops after one cycle with no new write
    chk(align_pulse == 1'b0, "R9 pulse width", 32'(align_pulse), 32'd0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    m_ref = '0; m_fb = '0; m_fn = '0; m_pend = 0;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    // R8 reset state
    check_regs(1'b0);

    // R1 R2 R3 R4 R5 sweep over address orders with arithmetic payloads
    for (int i = 0; i < 64; i++) begin
      logic [1:0] a;
      logic [31:0] v;
      a = 2'((i * 3 + i / 4) % 4);
      v = 32'(i) * 32'd40503 + 32'd12345;
      put(a, v[PAY_W-1:0] ^ PAY_W'(i << 5));
    end

    // R4 R5: init then three feedback writes
    put(2'd3, 22'h00_1234);
    put(2'd1, 22'h2A_AAAA);
    put(2'd1, 22'h15_5555);
    put(2'd1, 22'h00_0001);
    // R5: ref and fn writes between init and feedback do not fire, pending stays
    put(2'd3, 22'h00_0000);
    put(2'd0, 22'h3F_FFFF);
    put(2'd2, 22'h00_0040);
    put(2'd1, 22'h00_0002);
    // R6: hold bit alone, no power-down
    put(2'd2, 22'h00_0001);
    put(2'd2, 22'h3F_FFFE);

    // R8: pending cleared by reset
    put(2'd3, 22'h00_0ABC);
    do_reset();
    check_regs(1'b0);
    put(2'd1, 22'h00_0777);

    // R8: strobe during reset ignored
    @(negedge clk);
    rst = 1'b1;
    ld = 1'b1;
    word = {22'h3F_FFFF, 2'd3};
    @(negedge clk);
    rst = 1'b0;
    ld = 1'b0;
    m_ref = '0; m_fb = '0; m_fn = '0; m_pend = 0;
    check_regs(1'b0);
    put(2'd1, 22'h00_0101);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule